// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block produces the active-low system reset for a processor subsystem. An external comparator reports whether the supply is good, as a level already synchronous to the system clock. While that level is low, the reset output is held asserted. When the supply becomes good, the block keeps reset asserted for a fixed number of clock cycles, the power-on delay, and then releases it.

Once reset is released, a watchdog watches a toggle line driven by the host processor. Each high pulse on that line that lasts long enough counts as a kick and restarts the monitor window. If the window runs out without a kick, the block asserts reset for a reset interval one third as long as the window. It then releases reset and opens a new window, so a host that has stopped keeps cycling through window and reset. An inhibit input switches the watchdog off, and a parameter sets which inhibit level enables it. The host toggle line and the inhibit input are resynchronized inside the block. All delays are cycle counts given as parameters.

Top module: `supply_supervisor`

## Requirements
- R1: Whenever supply_ok_i is low at a clock edge, rst_n_o is low after that edge, whatever the block was doing.
- R2: When supply_ok_i rises and stays high, rst_n_o first goes high on the (POR_CYCLES+1)-th clock edge after the rise.
- R3: A loss of supply_ok_i during the power-on delay aborts it, and the next rise starts the full delay again.
- R4: With the watchdog enabled and no kicks, rst_n_o stays high for exactly MON_CYCLES clock edges after each release and then goes low.
- R5: A watchdog reset lasts MON_CYCLES/3 clock edges. Then rst_n_o goes high and a new monitor window of MON_CYCLES starts, so the cycle repeats.
- R6: A high pulse on host_clk_i that lasts at least MIN_PULSE clock cycles is a kick and restarts the monitor window. Kicks at intervals shorter than the window keep rst_n_o high.
- R7: High pulses on host_clk_i shorter than MIN_PULSE cycles have no effect on the monitor window.
- R8: The watchdog is enabled when inhibit_i equals WDT_ON_LEVEL (default 1). When it is disabled, rst_n_o depends only on the supply and the power-on delay, and it never drops because kicks are missing.
- R9: Disabling the watchdog during a watchdog reset releases rst_n_o on the third clock edge after the inhibit change (two synchronizer stages plus the state register).
- R10: While rst is high, rst_n_o is low. After rst is released with the supply good, the full power-on delay runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good level from the comparator, synchronous to clk |
| host_clk_i | input | 1 | Watchdog toggle line from the host, asynchronous |
| inhibit_i | input | 1 | Watchdog on/off control, asynchronous; polarity set by WDT_ON_LEVEL |
| rst_n_o | output | 1 | Registered active-low reset output |

## Verification
The hardest case to reach is a watchdog reset that is cut short by the inhibit input. The host has to stop kicking, a full monitor window has to expire, and the inhibit level then has to change inside the short reset phase. The bench waits for the falling edge of the reset output that marks the start of that phase, changes inhibit on the same cycle, and counts the cycles until release. A second instance with the opposite inhibit polarity runs on the same stimulus, so both enable levels are exercised at the same time.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DELAY = 2'd1,
    PH_MON   = 2'd2,
    PH_WRST  = 2'd3
  } phase_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kick_qual.sv
module kick_qual #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic kick_o
);
  localparam int HW = $clog2(MIN_PULSE + 1);
  localparam logic [HW-1:0] H_SAT  = HW'(MIN_PULSE);
  localparam logic [HW-1:0] H_LAST = HW'(MIN_PULSE - 1);

  logic [HW-1:0] hcnt_q;
  logic          kick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      kick_q <= 1'b0;
    end else begin
      if (!lvl_i)              hcnt_q <= '0;
      else if (hcnt_q != H_SAT) hcnt_q <= hcnt_q + 1'b1;
      kick_q <= lvl_i && (hcnt_q == H_LAST);
    end
  end

  assign kick_o = kick_q;

  // R7
  kick_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    kick_q |-> $past(lvl_i));
  // R6
  kick_single_chk: assert property (@(posedge clk) disable iff (rst)
    kick_q |=> !kick_q);
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
#(
  parameter int POR_CYCLES = 64,
  parameter int MON_CYCLES = 96,
  parameter int RST_CYCLES = 32,
  parameter int CW         = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic wdt_en_i,
  input  logic kick_i,
  output logic rst_n_o
);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] MON_LAST = CW'(MON_CYCLES - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          rst_n_q;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok_i) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      rst_n_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_OFF: begin
          phase_q <= PH_DELAY;
          cnt_q   <= '0;
          rst_n_q <= 1'b0;
        end
        PH_DELAY: begin
          if (cnt_q == POR_LAST) begin
            phase_q <= PH_MON;
            cnt_q   <= '0;
            rst_n_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_MON: begin
          if (!wdt_en_i || kick_i) begin
            cnt_q <= '0;
          end else if (cnt_q == MON_LAST) begin
            phase_q <= PH_WRST;
            cnt_q   <= '0;
            rst_n_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (!wdt_en_i || cnt_q == RST_LAST) begin
            phase_q <= PH_MON;
            cnt_q   <= '0;
            rst_n_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign rst_n_o = rst_n_q;

  // R1
  sup_low_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !rst_n_q);
  // R2
  rise_sup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> $past(supply_ok_i));
  // R4
  mon_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MON) |-> (cnt_q <= MON_LAST));
  // R5
  wrst_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WRST) |-> (cnt_q <= RST_LAST));
  // R4
  wdt_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_n_q) && $past(supply_ok_i)) |-> (phase_q == PH_WRST));
  // R8
  inh_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!wdt_en_i) && phase_q == PH_MON) |-> (cnt_q == '0));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int POR_CYCLES   = 1380000,
  parameter int MON_CYCLES   = 2000000,
  parameter int MIN_PULSE    = 100,
  parameter bit WDT_ON_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic host_clk_i,
  input  logic inhibit_i,
  output logic rst_n_o
);
  localparam int RST_CYCLES = MON_CYCLES / 3;
  localparam int CMAX       = (POR_CYCLES > MON_CYCLES) ? POR_CYCLES : MON_CYCLES;
  localparam int CW         = $clog2(CMAX + 1);

  logic [1:0] raw_in;
  logic [1:0] syn_in;
  logic       kick;
  logic       wdt_en;

  assign raw_in = {inhibit_i, host_clk_i};

  sup_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  kick_qual #(.MIN_PULSE(MIN_PULSE)) u_kick (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (syn_in[0]),
    .kick_o (kick)
  );

  generate
    if (WDT_ON_LEVEL) begin : g_en_high
      assign wdt_en = syn_in[1];
    end else begin : g_en_low
      assign wdt_en = ~syn_in[1];
    end
  endgenerate

  sup_fsm #(
    .POR_CYCLES (POR_CYCLES),
    .MON_CYCLES (MON_CYCLES),
    .RST_CYCLES (RST_CYCLES),
    .CW         (CW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .wdt_en_i    (wdt_en),
    .kick_i      (kick),
    .rst_n_o     (rst_n_o)
  );
endmodule

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;
  localparam int P   = 40;
  localparam int M   = 60;
  localparam int R   = M / 3;
  localparam int MIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic host_clk = 1'b0;
  logic inhibit = 1'b1;
  logic rst_n_main;
  logic rst_n_alt;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.POR_CYCLES(P), .MON_CYCLES(M), .MIN_PULSE(MIN),
                      .WDT_ON_LEVEL(1'b1)) u_supply_supervisor (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .host_clk_i(host_clk),
    .inhibit_i(inhibit), .rst_n_o(rst_n_main));

  supply_supervisor #(.POR_CYCLES(P), .MON_CYCLES(M), .MIN_PULSE(MIN),
                      .WDT_ON_LEVEL(1'b0)) u_alt (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .host_clk_i(host_clk),
    .inhibit_i(inhibit), .rst_n_o(rst_n_alt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_main(input logic val, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_n_main !== val && n < lim);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    chk(rst_n_main === 1'b0, "R10 reset low", rst_n_main, 0);
    chk(rst_n_alt === 1'b0, "R10 alt reset low", rst_n_alt, 0);
    supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(rst_n_main === 1'b0, "R10 held while rst", rst_n_main, 0);
    rst = 1'b0;
    wait_main(1'b1, 4 * P, n);
    chk(n == P + 1, "R10 por after rst release", n, P + 1);
  endtask

  task automatic t_por();
    int n;
    supply_ok = 1'b0;
    wait_main(1'b0, 10, n);
    chk(n == 1, "R1 supply loss in monitor", n, 1);
    repeat (4) @(negedge clk);
    supply_ok = 1'b1;
    wait_main(1'b1, 4 * P, n);
    chk(n == P + 1, "R2 power-on delay", n, P + 1);
  endtask

  task automatic t_por_abort();
    int n;
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    repeat (P / 2) @(negedge clk);
    chk(rst_n_main === 1'b0, "R3 low mid delay", rst_n_main, 0);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    wait_main(1'b1, 4 * P, n);
    chk(n == P + 1, "R3 delay restarted", n, P + 1);
  endtask

  task automatic t_window();
    int n;
    wait_main(1'b0, 4 * M, n);
    chk(n == M, "R4 monitor window", n, M);
    wait_main(1'b1, 4 * M, n);
    chk(n == R, "R5 reset phase", n, R);
    wait_main(1'b0, 4 * M, n);
    chk(n == M, "R5 window repeats", n, M);
    wait_main(1'b1, 4 * M, n);
    chk(n == R, "R5 reset phase repeats", n, R);
  endtask

  task automatic t_kick_long();
    int lows = 0;
    int n;
    for (int i = 1; i <= 3 * M; i++) begin
      @(negedge clk);
      if (rst_n_main !== 1'b1) lows++;
      host_clk = ((i % 25) >= 1) && ((i % 25) <= 8);
    end
    host_clk = 1'b0;
    chk(lows == 0, "R6 kicks hold reset off", lows, 0);
    wait_main(1'b0, 4 * M, n);
    wait_main(1'b1, 4 * M, n);
  endtask

  task automatic t_kick_short();
    int at = 0;
    int n;
    for (int i = 1; i <= M + 5; i++) begin
      @(negedge clk);
      if (at == 0 && rst_n_main === 1'b0) at = i;
      host_clk = ((i % 20) >= 1) && ((i % 20) <= MIN - 1);
    end
    host_clk = 1'b0;
    chk(at == M, "R7 short pulses ignored", at, M);
    wait_main(1'b1, 4 * M, n);
  endtask

  task automatic t_inhibit();
    int n;
    int lows = 0;
    int alt_lows = 0;
    wait_main(1'b0, 4 * M, n);
    inhibit = 1'b0;
    wait_main(1'b1, 20, n);
    chk(n == 3, "R9 disable releases reset", n, 3);
    for (int i = 0; i < 3 * M; i++) begin
      @(negedge clk);
      if (rst_n_main !== 1'b1) lows++;
    end
    chk(lows == 0, "R8 disabled watchdog quiet", lows, 0);
    inhibit = 1'b1;
    repeat (5) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 3 * M; i++) begin
      @(negedge clk);
      if (rst_n_main !== 1'b1) lows++;
      if (rst_n_alt !== 1'b1) alt_lows++;
    end
    chk(lows > 0, "R8 enabled main fires", lows, 1);
    chk(alt_lows == 0, "R8 inverted polarity disabled", alt_lows, 0);
  endtask

  task automatic t_loss();
    int n;
    wait_main(1'b1, 4 * M, n);
    repeat (5) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk(rst_n_main === 1'b0, "R1 main forced low", rst_n_main, 0);
    chk(rst_n_alt === 1'b0, "R1 alt forced low", rst_n_alt, 0);
    supply_ok = 1'b1;
    wait_main(1'b1, 4 * P, n);
    chk(n == P + 1, "R2 delay after loss", n, P + 1);
  endtask

  initial begin
    t_reset();
    t_por();
    t_por_abort();
    t_window();
    t_kick_long();
    t_kick_short();
    t_inhibit();
    t_loss();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule